// File: doc/BRIEF.md
# Network Controller Power-State Sequencer

This block is the power-management state machine of a network controller that sits on a host bus. It decides whether the controller runs normally, waits in a low-power state for a wakeup frame, or drops all traffic. It makes that decision from three things: the wakeup-enable bit delivered when the EEPROM load completes, whether the host bus is powered, and later software writes to the wakeup-enable bit. The bus counts as powered when its three read/write strobes are all low together.

In the two low-power states the block asks the frame path to discard every ordinary frame. When a wakeup frame is recognised there, it drives a timed wake pulse. When the pulse is started from the powered-bus low-power state and interrupts are enabled, a host interrupt request goes with it. The pulse length is one prescaled tick times a tick count, and both are parameters. At the end of a pulse from the unpowered low-power state, the block checks bus power again. It then either goes back to waiting or falls into reset.

The block also guards the host side. Bus drivers stay off after any reset until all three strobes have been seen high. Host accesses are refused while the block waits for the EEPROM load.

Top module: `nic_pwr_seq`

## Requirements
- R1: While `host_rst` is high (asynchronous) and right after it falls, `state` is 0 (RESET), `acc_grant`=0, `drv_en`=0, `drop_frames`=1, `wake_out`=0 and `irq_req`=0.
- R2: `state` encodes RESET=0, NORMAL=1, STANDBY=2, SUSPEND=3, DROP=4. In RESET, a cycle with `cfg_done`=1 moves the block on the next clock to: NORMAL for enable 0 with the bus powered, DROP for enable 0 with the bus unpowered, STANDBY for enable 1 with the bus powered, and SUSPEND for enable 1 with the bus unpowered. The enable bit is `cfg_wake_en`.
- R3: The bus counts as powered only when `mem_rd_n`, `mem_wr_n` and `io_rd_n`, each taken through a two-flop synchroniser, are all 0 in the same cycle. Any other mix counts as unpowered.
- R4: `drv_en` is 1 only in NORMAL or STANDBY, and only after all three strobes have been seen high together since the last entry to RESET. From the cycle the strobes go high at the pins, `drv_en` rises three clocks later.
- R5: `drop_frames` is 0 only in NORMAL. `acc_grant` is 0 only in RESET.
- R6: A `wake_frame` cycle in STANDBY or SUSPEND raises `wake_out` on the next clock. `wake_out` then stays high for exactly PRESCALE*PULSE_MS cycles. Further `wake_frame` cycles during a pulse have no effect on its length.
- R7: `wake_frame` in RESET, NORMAL or DROP produces no pulse.
- R8: When a pulse started in SUSPEND ends, the block stays in SUSPEND if the bus is unpowered. If the bus is powered, it enters RESET, with drivers and access turned off again.
- R9: In NORMAL, `sw_wr`=1 with `sw_wake_en`=1 moves the block to STANDBY. In STANDBY, `sw_wr`=1 with `sw_wake_en`=0 moves it back to NORMAL.
- R10: `irq_req` rises with `wake_out` only when the pulse starts in STANDBY with `irq_en`=1. It falls when the pulse ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| host_rst | input | 1 | Asynchronous host reset, active high |
| mem_rd_n | input | 1 | Host memory-read strobe, active low |
| mem_wr_n | input | 1 | Host memory-write strobe, active low |
| io_rd_n | input | 1 | Host I/O-read strobe, active low |
| cfg_done | input | 1 | EEPROM load complete |
| cfg_wake_en | input | 1 | Wakeup-enable bit from the EEPROM load |
| sw_wr | input | 1 | Software write strobe for the wakeup-enable bit |
| sw_wake_en | input | 1 | Value written by software |
| wake_frame | input | 1 | Wakeup frame recognised |
| irq_en | input | 1 | Host interrupts enabled |
| state | output | 3 | Current power state |
| drop_frames | output | 1 | Discard non-wakeup frames |
| drv_en | output | 1 | Host bus driver enable |
| acc_grant | output | 1 | Host accesses permitted |
| wake_out | output | 1 | Timed wake pulse |
| irq_req | output | 1 | Host interrupt request with the wake pulse |

## Verification
The bench walks every entry of the exit table, using random strobe mixes that are not all low. A design that treated a single low strobe as a powered bus would land in NORMAL or STANDBY instead of DROP or SUSPEND. It holds the strobes low through reset and checks that the drivers stay off until the strobes go high. A design that enabled drivers on leaving reset would fail there. It changes bus power in the middle of a pulse in SUSPEND. A design that sampled power at the pulse start, or never checked it again, would stay in SUSPEND or reset wrongly. It also sends extra wakeup frames during a pulse, which a design that restarts its counter would stretch.

// File: rtl/nic_pwr_seq.sv
module nic_pwr_seq #(
  parameter int PRESCALE = 25000,
  parameter int PULSE_MS = 52
) (
  input  logic       clk,
  input  logic       host_rst,
  input  logic       mem_rd_n,
  input  logic       mem_wr_n,
  input  logic       io_rd_n,
  input  logic       cfg_done,
  input  logic       cfg_wake_en,
  input  logic       sw_wr,
  input  logic       sw_wake_en,
  input  logic       wake_frame,
  input  logic       irq_en,
  output logic [2:0] state,
  output logic       drop_frames,
  output logic       drv_en,
  output logic       acc_grant,
  output logic       wake_out,
  output logic       irq_req
);
  localparam int PW = $clog2(PRESCALE + 1);
  localparam int MW = $clog2(PULSE_MS + 1);
  localparam logic [2:0] S_RST  = 3'd0;
  localparam logic [2:0] S_NORM = 3'd1;
  localparam logic [2:0] S_STBY = 3'd2;
  localparam logic [2:0] S_SUSP = 3'd3;
  localparam logic [2:0] S_DROP = 3'd4;

  logic [2:0]    strb_s1, strb_s2;
  logic [2:0]    nxt;
  logic [PW-1:0] pre;
  logic [MW-1:0] ms;
  logic          hi_seen;

  always_ff @(posedge clk or posedge host_rst)
    if (host_rst) begin
      strb_s1 <= '0;
      strb_s2 <= '0;
    end else begin
      strb_s1 <= {mem_rd_n, mem_wr_n, io_rd_n};
      strb_s2 <= strb_s1;
    end

  wire bus_pwr    = (strb_s2 == 3'b000);
  wire all_hi     = &strb_s2;
  wire low_pwr    = (state == S_STBY) || (state == S_SUSP);
  wire wake_start = !wake_out && wake_frame && low_pwr;
  wire pre_last   = (pre == PW'(PRESCALE - 1));
  wire pulse_end  = wake_out && pre_last && (ms == MW'(PULSE_MS - 1));
  wire to_reset   = pulse_end && (state == S_SUSP) && bus_pwr;

  always_comb begin
    nxt = state;
    case (state)
      S_RST:   if (cfg_done)
                 nxt = cfg_wake_en ? (bus_pwr ? S_STBY : S_SUSP)
                                   : (bus_pwr ? S_NORM : S_DROP);
      S_NORM:  if (sw_wr && sw_wake_en) nxt = S_STBY;
      S_STBY:  if (sw_wr && !sw_wake_en) nxt = S_NORM;
      S_SUSP:  if (to_reset) nxt = S_RST;
      default: nxt = state;
    endcase
  end

  always_ff @(posedge clk or posedge host_rst)
    if (host_rst) state <= S_RST;
    else          state <= nxt;

  always_ff @(posedge clk or posedge host_rst)
    if (host_rst)      hi_seen <= 1'b0;
    else if (to_reset) hi_seen <= 1'b0;
    else if (all_hi)   hi_seen <= 1'b1;

  always_ff @(posedge clk or posedge host_rst)
    if (host_rst) begin
      wake_out <= 1'b0;
      irq_req  <= 1'b0;
      pre      <= '0;
      ms       <= '0;
    end else if (wake_start) begin
      wake_out <= 1'b1;
      irq_req  <= (state == S_STBY) && irq_en;
      pre      <= '0;
      ms       <= '0;
    end else if (wake_out) begin
      if (pre_last) begin
        pre <= '0;
        if (pulse_end) begin
          ms       <= '0;
          wake_out <= 1'b0;
          irq_req  <= 1'b0;
        end else begin
          ms <= ms + MW'(1);
        end
      end else begin
        pre <= pre + PW'(1);
      end
    end

  assign drop_frames = (state != S_NORM);
  assign acc_grant   = (state != S_RST);
  assign drv_en      = hi_seen && ((state == S_NORM) || (state == S_STBY));
endmodule

// File: rtl/nic_pwr_seq_chk.sv
module nic_pwr_seq_chk #(
  parameter int N = 4
) (
  input logic       clk,
  input logic       host_rst,
  input logic [2:0] state,
  input logic       cfg_done,
  input logic       cfg_wake_en,
  input logic       bus_pwr,
  input logic       wake_frame,
  input logic       wake_out,
  input logic       irq_req,
  input logic       drv_en,
  input logic       acc_grant,
  input logic       sw_wr,
  input logic       sw_wake_en
);
  int cnt;

  always_ff @(posedge clk or posedge host_rst)
    if (host_rst)      cnt <= 0;
    else if (wake_out) cnt <= cnt + 1;
    else               cnt <= 0;

  a_r1_legal_state: assert property (@(posedge clk) disable iff (host_rst)
    state <= 3'd4);

  a_r2_exit_table: assert property (@(posedge clk) disable iff (host_rst)
    (state == 3'd0 && cfg_done) |=>
      state == ($past(cfg_wake_en) ? ($past(bus_pwr) ? 3'd2 : 3'd3)
                                   : ($past(bus_pwr) ? 3'd1 : 3'd4)));

  a_r4_drv_needs_grant: assert property (@(posedge clk) disable iff (host_rst)
    drv_en |-> acc_grant);

  a_r6_pulse_width: assert property (@(posedge clk) disable iff (host_rst)
    $fell(wake_out) |-> cnt == N);

  a_r6_pulse_bound: assert property (@(posedge clk) disable iff (host_rst)
    wake_out |-> cnt < N);

  a_r7_start_source: assert property (@(posedge clk) disable iff (host_rst)
    $rose(wake_out) |-> ($past(wake_frame) &&
                         ($past(state) == 3'd2 || $past(state) == 3'd3)));

  a_r9_to_standby: assert property (@(posedge clk) disable iff (host_rst)
    (state == 3'd1 && sw_wr && sw_wake_en) |=> state == 3'd2);

  a_r10_irq_in_pulse: assert property (@(posedge clk) disable iff (host_rst)
    irq_req |-> wake_out);
endmodule

bind nic_pwr_seq nic_pwr_seq_chk #(.N(PRESCALE * PULSE_MS)) u_chk (
  .clk(clk), .host_rst(host_rst), .state(state), .cfg_done(cfg_done),
  .cfg_wake_en(cfg_wake_en), .bus_pwr(bus_pwr), .wake_frame(wake_frame),
  .wake_out(wake_out), .irq_req(irq_req), .drv_en(drv_en),
  .acc_grant(acc_grant), .sw_wr(sw_wr), .sw_wake_en(sw_wake_en)
);

// File: tb/tb_nic_pwr_seq.sv
module tb_nic_pwr_seq;
  localparam int PS = 3;
  localparam int PM = 4;
  localparam int NP = PS * PM;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic host_rst = 1'b1;
  logic mem_rd_n = 1'b1, mem_wr_n = 1'b1, io_rd_n = 1'b1;
  logic cfg_done = 1'b0, cfg_wake_en = 1'b0;
  logic sw_wr = 1'b0, sw_wake_en = 1'b0;
  logic wake_frame = 1'b0, irq_en = 1'b0;
  logic [2:0] state;
  logic drop_frames, drv_en, acc_grant, wake_out, irq_req;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  nic_pwr_seq #(.PRESCALE(PS), .PULSE_MS(PM)) dut (
    .clk(clk), .host_rst(host_rst), .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n),
    .io_rd_n(io_rd_n), .cfg_done(cfg_done), .cfg_wake_en(cfg_wake_en),
    .sw_wr(sw_wr), .sw_wake_en(sw_wake_en), .wake_frame(wake_frame),
    .irq_en(irq_en), .state(state), .drop_frames(drop_frames),
    .drv_en(drv_en), .acc_grant(acc_grant), .wake_out(wake_out),
    .irq_req(irq_req)
  );

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic int exit_st(bit en, bit pwr);
    return en ? (pwr ? 2 : 3) : (pwr ? 1 : 4);
  endfunction

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_bus(bit pwr);
    if (pwr) {mem_rd_n, mem_wr_n, io_rd_n} = 3'b000;
    else begin
      logic [2:0] v;
      do v = 3'($urandom); while (v == 3'b000);
      {mem_rd_n, mem_wr_n, io_rd_n} = v;
    end
  endtask

  task automatic do_reset();
    host_rst = 1'b1;
    cfg_done = 1'b0; sw_wr = 1'b0; wake_frame = 1'b0;
    cyc(2);
    chk("R1 state in reset", int'(state), 0);
    host_rst = 1'b0;
    chk("R1 state", int'(state), 0);
    chk("R1 acc_grant", int'(acc_grant), 0);
    chk("R1 drv_en", int'(drv_en), 0);
    chk("R1 drop_frames", int'(drop_frames), 1);
    chk("R1 wake_out", int'(wake_out), 0);
    chk("R1 irq_req", int'(irq_req), 0);
  endtask

  task automatic run_trial(bit en, bit pwr, bit irq, bit mid, bit extra, bit back);
    int exp;
    int w;
    do_reset();
    {mem_rd_n, mem_wr_n, io_rd_n} = 3'b111;
    cyc(4);
    set_bus(pwr);
    cyc(4);
    wake_frame = 1'b1; cyc(1); wake_frame = 1'b0; cyc(1);
    chk("R7 no pulse in RESET", int'(wake_out), 0);
    cfg_wake_en = en; cfg_done = 1'b1; cyc(1); cfg_done = 1'b0;
    exp = exit_st(en, pwr);
    chk("R2 exit state", int'(state), exp);
    chk("R3 power decode via exit", int'(state), exp);
    chk("R5 acc_grant", int'(acc_grant), 1);
    chk("R5 drop_frames", int'(drop_frames), (exp != 1) ? 1 : 0);
    chk("R4 drv_en", int'(drv_en), (exp == 1 || exp == 2) ? 1 : 0);
    irq_en = irq;
    if (exp == 1 || exp == 4) begin
      wake_frame = 1'b1; cyc(1); wake_frame = 1'b0;
      chk("R7 no pulse", int'(wake_out), 0);
      cyc(2);
      chk("R7 still no pulse", int'(wake_out), 0);
    end
    if (exp == 4) chk("R4 drv off in DROP", int'(drv_en), 0);
    if (exp == 1) begin
      sw_wake_en = 1'b1; sw_wr = 1'b1; cyc(1); sw_wr = 1'b0;
      chk("R9 NORMAL to STANDBY", int'(state), 2);
      exp = 2;
    end
    if (exp == 2 || exp == 3) begin
      wake_frame = 1'b1; cyc(1); wake_frame = 1'b0;
      chk("R6 pulse start", int'(wake_out), 1);
      chk("R10 irq at start", int'(irq_req), (exp == 2 && irq) ? 1 : 0);
      w = 0;
      while (wake_out === 1'b1 && w < 200) begin
        w++;
        if (w == 2 && mid) set_bus(!pwr);
        wake_frame = (w == 4 && extra);
        cyc(1);
      end
      wake_frame = 1'b0;
      chk("R6 pulse width", w, NP);
      chk("R10 irq cleared", int'(irq_req), 0);
      if (exp == 3) begin
        if (mid) begin
          chk("R8 powered -> RESET", int'(state), 0);
          chk("R8 drivers off", int'(drv_en), 0);
          chk("R8 access off", int'(acc_grant), 0);
        end else begin
          chk("R8 unpowered -> SUSPEND", int'(state), 3);
          chk("R4 drv off in SUSPEND", int'(drv_en), 0);
        end
      end else begin
        chk("R6 stays STANDBY", int'(state), 2);
        if (back) begin
          sw_wake_en = 1'b0; sw_wr = 1'b1; cyc(1); sw_wr = 1'b0;
          chk("R9 STANDBY to NORMAL", int'(state), 1);
          chk("R5 drop off in NORMAL", int'(drop_frames), 0);
        end
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=0 exp=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd8191));
    cyc(2);
    // R4: strobes held low through reset, drivers wait for all-high
    do_reset();
    {mem_rd_n, mem_wr_n, io_rd_n} = 3'b000;
    cyc(4);
    cfg_wake_en = 1'b0; cfg_done = 1'b1; cyc(1); cfg_done = 1'b0;
    chk("R2 NORMAL", int'(state), 1);
    chk("R4 drv off before high", int'(drv_en), 0);
    {mem_rd_n, mem_wr_n, io_rd_n} = 3'b111;
    cyc(2);
    chk("R4 drv still off", int'(drv_en), 0);
    cyc(1);
    chk("R4 drv on after high", int'(drv_en), 1);
    // directed corners
    run_trial(0, 1, 0, 0, 0, 1);
    run_trial(0, 0, 0, 0, 0, 0);
    run_trial(1, 1, 1, 0, 1, 1);
    run_trial(1, 0, 0, 0, 0, 0);
    run_trial(1, 0, 1, 1, 1, 0);
    run_trial(1, 1, 1, 1, 0, 0);
    for (int i = 0; i < 40; i++)
      run_trial(1'($urandom), 1'($urandom), 1'($urandom),
                1'($urandom), 1'($urandom), 1'($urandom));
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule